// File: doc/BRIEF.md
# MDIO Management Frame Controller

This block turns one 32-bit command register into clause-22 management frames on the MDC clock and the bidirectional MDIO data line. Software writes a command word that holds a start flag, a direction bit, a 5-bit PHY address, a 5-bit register number and 16 bits of write data. The controller then emits the full frame: preamble, start code, opcode, the two addresses, turnaround and data, most significant bit first.

The start flag also serves as the busy indication. It reads back as 1 for the whole frame and clears when the last data bit is done. For a read, the controller releases MDIO from the turnaround onward. It samples the PHY's data on each rising MDC edge, and when the flag clears the result sits in the low half of the same register. MDC comes from the system clock through a parameterised half-period divider. With the default setting a 100 MHz clock gives 2.5 MHz.

Top module: `mdio_acc_ctrl`

## Requirements
- R1: After reset the register reads 0, MDC is low and the MDIO output enable is low.
- R2: A write with bit 31 set loads the register and starts a frame. Bit 31 reads 1 from the next cycle until the frame ends, 64 MDC periods later, and then clears.
- R3: Every frame is sent MSB first on the MDC falling edge. It consists of 32 ones, start code 01, an opcode (01 when bit 30 is 1 = write, 10 when bit 30 is 0 = read), the PHY address from bits 25:21 and the register number from bits 20:16.
- R4: A write frame drives turnaround 10 and then data bits 15:0, with the output enable high for all 64 bits. At the end the register reads the issued word with bit 31 cleared.
- R5: A read frame drops the output enable from the first turnaround bit (bit 46 of the frame) to the end. It samples MDIO on each rising MDC edge of the 16 data bits. At the end, bits 15:0 hold the sampled data MSB first and bits 30:16 are unchanged.
- R6: MDC is low while idle. While a frame runs, each MDC level lasts DIV_HALF clock cycles, so a period is 2*DIV_HALF cycles.
- R7: A register write while bit 31 reads 1 is ignored. The register contents and the frame in progress are unaffected.
- R8: A write with bit 31 clear stores the word but starts no frame, and MDC stays low.
- R9: Writing 0xC0A09000 sends a write of 0x9000 to register 0 of PHY address 5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| wr_data_i | input | 32 | Command word to write |
| rd_data_o | output | 32 | Register contents: busy flag, fields, data |
| mdc_o | output | 1 | Management clock |
| mdio_o | output | 1 | MDIO output value |
| mdio_oe_o | output | 1 | MDIO output enable (0 = released) |
| mdio_i | input | 1 | MDIO input value |

## Verification
The hardest case to reach is the read turnaround. There the controller must already have let go of the line while the PHY model starts driving, and each data bit must be stable at the rising MDC edge where it is sampled. The bench acts as a PHY. It counts MDC rises, records the line value and the enable at each rise, and changes its own drive only on MDC falling edges. A sweep over all 32 PHY addresses, in both directions, checks the recorded bits against a frame built arithmetically. Every fourth frame also gets a write injected in mid-flight.

// File: rtl/mdio_acc_pkg.sv
package mdio_acc_pkg;
  localparam int FRAME_BITS   = 64;
  localparam int PRE_BITS     = 32;
  localparam int RELEASE_BIT  = PRE_BITS + 14;   // first turnaround bit
  localparam int DATA_BIT     = RELEASE_BIT + 2; // first data bit
  localparam int CNT_W        = $clog2(FRAME_BITS);

  localparam int START_POS = 31;
  localparam int WRITE_POS = 30;

  function automatic logic [FRAME_BITS-1:0] build_frame(input logic [31:0] cmd);
    logic [1:0] op;
    op = cmd[WRITE_POS] ? 2'b01 : 2'b10;
    return {{PRE_BITS{1'b1}}, 2'b01, op, cmd[25:21], cmd[20:16], 2'b10, cmd[15:0]};
  endfunction
endpackage

// File: rtl/mdc_div.sv
module mdc_div #(
  parameter int DIV_HALF = 20
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic mdc_o,
  output logic rise_o,
  output logic fall_o
);
  localparam int CW = $clog2(DIV_HALF) + 1;
  localparam logic [CW-1:0] LAST = CW'(DIV_HALF - 1);

  logic [CW-1:0] cnt_q;
  logic          mdc_q;
  logic          term;

  assign term = run_i && (cnt_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      mdc_q <= 1'b0;
    end else if (!run_i) begin
      cnt_q <= '0;
      mdc_q <= 1'b0;
    end else if (term) begin
      cnt_q <= '0;
      mdc_q <= ~mdc_q;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign mdc_o  = mdc_q;
  assign rise_o = term && !mdc_q;
  assign fall_o = term && mdc_q;
endmodule

// File: rtl/mdio_frame_seq.sv
module mdio_frame_seq
  import mdio_acc_pkg::*;
(
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  start_i,
  input  logic [FRAME_BITS-1:0] frame_i,
  input  logic                  active_i,
  input  logic                  is_wr_i,
  input  logic                  rise_i,
  input  logic                  fall_i,
  input  logic                  mdio_i,
  output logic                  mdio_o,
  output logic                  mdio_oe_o,
  output logic                  done_o,
  output logic [15:0]           rx_o
);
  logic [FRAME_BITS-1:0] sr_q;
  logic [CNT_W-1:0]      bit_q;
  logic [15:0]           rx_q;
  logic                  in_data;

  assign in_data = bit_q >= CNT_W'(DATA_BIT);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sr_q  <= '0;
      bit_q <= '0;
      rx_q  <= '0;
    end else if (start_i) begin
      sr_q  <= frame_i;
      bit_q <= '0;
    end else if (active_i) begin
      if (rise_i && !is_wr_i && in_data) rx_q <= {rx_q[14:0], mdio_i};
      if (fall_i) begin
        sr_q  <= {sr_q[FRAME_BITS-2:0], 1'b0};
        bit_q <= bit_q + 1'b1;
      end
    end
  end

  assign mdio_o    = active_i && sr_q[FRAME_BITS-1];
  assign mdio_oe_o = active_i && (is_wr_i || bit_q < CNT_W'(RELEASE_BIT));
  assign done_o    = active_i && fall_i && (bit_q == CNT_W'(FRAME_BITS - 1));
  assign rx_o      = rx_q;
endmodule

// File: rtl/mdio_acc_ctrl.sv
module mdio_acc_ctrl
  import mdio_acc_pkg::*;
#(
  parameter int DIV_HALF = 20
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        wr_en_i,
  input  logic [31:0] wr_data_i,
  output logic [31:0] rd_data_o,
  output logic        mdc_o,
  output logic        mdio_o,
  output logic        mdio_oe_o,
  input  logic        mdio_i
);
  logic [31:0] cmd_q;
  logic        busy, accept, start, rise, fall, done;
  logic [15:0] rx;

  assign busy   = cmd_q[START_POS];
  assign accept = wr_en_i && !busy;
  assign start  = accept && wr_data_i[START_POS];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cmd_q <= '0;
    end else if (accept) begin
      cmd_q <= wr_data_i;
    end else if (done) begin
      cmd_q[START_POS] <= 1'b0;
      if (!cmd_q[WRITE_POS]) cmd_q[15:0] <= rx;
    end
  end

  mdc_div #(.DIV_HALF(DIV_HALF)) u_div (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (busy),
    .mdc_o  (mdc_o),
    .rise_o (rise),
    .fall_o (fall)
  );

  mdio_frame_seq u_seq (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .start_i   (start),
    .frame_i   (build_frame(wr_data_i)),
    .active_i  (busy),
    .is_wr_i   (cmd_q[WRITE_POS]),
    .rise_i    (rise),
    .fall_i    (fall),
    .mdio_i    (mdio_i),
    .mdio_o    (mdio_o),
    .mdio_oe_o (mdio_oe_o),
    .done_o    (done),
    .rx_o      (rx)
  );

  assign rd_data_o = cmd_q;
endmodule

module mdio_acc_chk #(
  parameter int DIV_HALF = 20
) (
  input logic        clk_i,
  input logic        rst_ni,
  input logic [31:0] rd_data_o,
  input logic        mdc_o,
  input logic        mdio_oe_o
);
  logic mdc_d;
  int   hold;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mdc_d <= 1'b0;
      hold  <= 0;
    end else begin
      mdc_d <= mdc_o;
      if (!rd_data_o[31] || mdc_o != mdc_d) hold <= 0;
      else hold <= hold + 1;
    end
  end

  // R1
  idle_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_data_o[31] |-> !mdio_oe_o);
  // R6
  idle_mdc_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_data_o[31] |-> !mdc_o);
  // R6
  mdc_half_len_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_data_o[31] |-> hold <= DIV_HALF);
  // R4
  wr_drive_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_data_o[31] && rd_data_o[30]) |-> mdio_oe_o);
  // R5
  rd_stay_released_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_data_o[31] && !rd_data_o[30] && !mdio_oe_o) |=> (!mdio_oe_o || !rd_data_o[31]));
  // R7
  fields_frozen_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_data_o[31] |=> rd_data_o[30:16] == $past(rd_data_o[30:16]));
endmodule

bind mdio_acc_ctrl mdio_acc_chk #(.DIV_HALF(DIV_HALF)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .rd_data_o (rd_data_o),
  .mdc_o     (mdc_o),
  .mdio_oe_o (mdio_oe_o)
);

// File: tb/sim_mdio_acc_ctrl.sv
`timescale 1ns/1ps
module sim_mdio_acc_ctrl;
  localparam int DIV_HALF = 2;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  logic        mdc, mdio_o, mdio_oe, mdio_i = 1'b1;

  int errors = 0, checks = 0, cyc = 0, last_rise = 0, rc = 0;
  logic [63:0] cap, oec;
  logic [15:0] rdpat = '0;

  mdio_acc_ctrl #(.DIV_HALF(DIV_HALF)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_data_i(wr_data),
    .rd_data_o(rd_data), .mdc_o(mdc), .mdio_o(mdio_o), .mdio_oe_o(mdio_oe),
    .mdio_i(mdio_i)
  );

  always #5 clk = ~clk;
  always @(posedge clk) cyc = cyc + 1;

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // PHY model: record at MDC rise, change drive at MDC fall
  always @(posedge mdc) begin
    if (rc > 0) chk(cyc - last_rise == 2*DIV_HALF, "R6 mdc period", 64'(cyc - last_rise), 64'(2*DIV_HALF));
    last_rise = cyc;
    if (rc < 64) begin
      cap[63-rc] = mdio_oe ? mdio_o : mdio_i;
      oec[63-rc] = mdio_oe;
    end
    rc++;
  end
  always @(negedge mdc) begin
    if (rc == 47) mdio_i = 1'b0;
    else if (rc >= 48 && rc < 64) mdio_i = rdpat[63-rc];
    else mdio_i = 1'b1;
  end

  function automatic logic [63:0] exp_frame(input logic [31:0] w, input logic [15:0] rp);
    return {32'hFFFF_FFFF, 2'b01, (w[30] ? 2'b01 : 2'b10), w[25:21], w[20:16], 2'b10,
            (w[30] ? w[15:0] : rp)};
  endfunction

  task automatic do_frame(input logic [31:0] w, input logic [15:0] rp, input bit inject);
    logic [31:0] exp_reg;
    int n;
    rc = 0; rdpat = rp; mdio_i = 1'b1;
    @(negedge clk); wr_en = 1'b1; wr_data = w;
    @(negedge clk); wr_en = 1'b0;
    chk(rd_data == w, "R2 busy after start", 64'(rd_data), 64'(w));
    n = 0;
    while (rd_data[31] && n < 2000) begin
      if (inject && n == 40) begin wr_en = 1'b1; wr_data = ~w | 32'h8000_0000; end
      if (inject && n == 41) begin
        wr_en = 1'b0;
        chk(rd_data == w, "R7 write while busy", 64'(rd_data), 64'(w));
      end
      @(negedge clk); n++;
    end
    wr_en = 1'b0;
    chk(n == 64*2*DIV_HALF, "R2 frame length", 64'(n), 64'(64*2*DIV_HALF));
    chk(rc == 64, "R3 rise count", 64'(rc), 64'd64);
    chk(cap == exp_frame(w, rp), w[30] ? "R4 write frame" : "R5 read frame", cap, exp_frame(w, rp));
    chk(oec == (w[30] ? 64'hFFFF_FFFF_FFFF_FFFF : 64'hFFFF_FFFF_FFFC_0000),
        "R5 output enable", oec, w[30] ? 64'hFFFF_FFFF_FFFF_FFFF : 64'hFFFF_FFFF_FFFC_0000);
    exp_reg = w[30] ? {1'b0, w[30:0]} : {1'b0, w[30:16], rp};
    chk(rd_data == exp_reg, w[30] ? "R4 result" : "R5 result", 64'(rd_data), 64'(exp_reg));
    chk(!mdc && !mdio_oe, "R6 idle after frame", 64'({mdc, mdio_oe}), 64'd0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(rd_data == 0 && !mdc && !mdio_oe, "R1 reset state", 64'({rd_data, mdc, mdio_oe}), 64'd0);
    rst_n = 1'b1;
    @(negedge clk);

    // R9 documented example
    do_frame(32'hC0A0_9000, 16'h0000, 1'b0);
    chk(cap[29:18] == {2'b01, 5'd5, 5'd0}, "R9 opcode/phy/reg", 64'(cap[29:18]), 64'({2'b01, 5'd5, 5'd0}));

    // R8 no start
    @(negedge clk); wr_en = 1'b1; wr_data = 32'h4123_ABCD; rc = 0;
    @(negedge clk); wr_en = 1'b0;
    repeat (20) @(negedge clk);
    chk(rd_data == 32'h4123_ABCD && rc == 0 && !mdc, "R8 store without frame",
        64'({rd_data, 8'(rc)}), 64'({32'h4123_ABCD, 8'd0}));

    // R3 R4 R5 R7 sweep over PHY addresses, both directions
    for (int p = 0; p < 32; p++) begin
      logic [4:0]  pa, ra;
      logic [15:0] d;
      pa = 5'(p); ra = 5'(31 - p); d = 16'(p * 16'h0831 + 16'h5A3C);
      do_frame({2'b11, 4'b0, pa, ra, d}, 16'hFFFF, (p % 4) == 0);
      do_frame({2'b10, 4'b0, pa, ra, d}, ~d ^ 16'(p), (p % 4) == 2);
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule